// File: doc/BRIEF.md
# Indexed PLL Register Port

The block is a two-location register window through which a host reaches a small bank of clock-control registers. Location 0 is an index byte. Location 1 is a 32-bit data port that reads or writes the register the index selects. The bank holds a PLL control word, a reference-divider word, a feedback/post-divider word and a pixel-clock source select.

Divider writes land in a staging set only. The live divider outputs that drive the PLL change only when the host requests a commit through the reference-divider word. A busy flag then stays high for a fixed number of cycles. At the end of that wait, every staged field is copied into the active set on one clock edge. The host polls the busy flag, then waits for the lock indication before it moves the pixel clock back from the CPU clock to the PLL output.

Top module: `pll_index_port`

## Requirements
- R1: The index location (select 0) stores the address in bits [5:0] and the write-enable flag in bit 7. Bit 6 and bits [31:8] read as 0. Every field of the index resets to 0.
- R2: A data-port write (select 1) changes the selected register only while the index write-enable bit is 1. If that bit is 0, no register changes. Reads change nothing.
- R3: Register map. Index 0x02 is control: bit 0 PLL reset, bit 1 sleep, bit 15 atomic-update enable, bit 16 legacy atomic-update enable, bit 31 the read-only lock flag. Index 0x03 is the reference divider: bits [9:0] divider, bit 15 commit request (write only, reads 0), bit 16 busy (read only). Index 0x07 holds the feedback divider in bits [10:0] and the post divider in bits [18:16]. Index 0x0D holds the pixel-clock source in bits [1:0], where 0 is the CPU clock and 3 is the PLL output. All other bits read 0.
- R4: An index that is not implemented reads as 0, and writes to it have no effect.
- R5: Writing 1 to bit 15 of index 0x03 with write enable set raises busy. Busy stays high for exactly COMMIT_WAIT cycles (default 8), far below 10000 host polls. A request made while busy is high is ignored and does not extend the wait.
- R6: The active divider outputs change only on the commit edge. On that edge all three fields are copied together from the staged values held before the edge. A staging write made in the same cycle stays in staging only.
- R7: pll_reset_o and pll_sleep_o follow control bits 0 and 1. pix_clk_sel_o follows bits [1:0] of index 0x0D.
- R8: pll_locked_o is 0 while reset or sleep is set and on the cycle after a commit. It rises once LOCK_CYCLES (default 32) consecutive cycles have passed with neither a commit nor a hold. It also reads back as control bit 31.
- R9: A dummy access has no side effects. The sequence is: read the index, write index 0 with write enable clear, read the data port, write the saved index back.
- R10: After reset all registers and outputs are 0, busy is 0 and the pixel clock selects the CPU clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | 0 = index location, 1 = data port |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data of the selected location (combinational) |
| ref_div_o | output | 10 | Active reference divider |
| fb_div_o | output | 11 | Active feedback divider |
| post_div_o | output | 3 | Active post-divider code |
| pll_reset_o | output | 1 | PLL reset request |
| pll_sleep_o | output | 1 | PLL sleep request |
| pix_clk_sel_o | output | 2 | Pixel-clock source select |
| pll_locked_o | output | 1 | Lock-wait indication |

## Verification
The commit edge and a host staging write can fall in the same cycle. The bench times a feedback-divider write to land exactly COMMIT_WAIT cycles after a commit request. It then judges that the active output carries the old staged value and that the staged readback holds the new one. A second commit must carry the new value through. A second overlap, a commit request issued while busy is already high, is judged by counting the remaining busy cycles, which must not restart.

// File: rtl/pll_idx_pkg.sv
`timescale 1ns/1ps
package pll_idx_pkg;
  localparam int ADDR_W   = 6;
  localparam int WE_BIT   = 7;
  localparam int REF_W    = 10;
  localparam int FB_W     = 11;
  localparam int POST_W   = 3;
  localparam int SEL_W    = 2;
  localparam int POST_LSB = 16;

  localparam logic [ADDR_W-1:0] IDX_CTRL   = 6'h02;
  localparam logic [ADDR_W-1:0] IDX_REFDIV = 6'h03;
  localparam logic [ADDR_W-1:0] IDX_FBPOST = 6'h07;
  localparam logic [ADDR_W-1:0] IDX_CLKSEL = 6'h0D;

  localparam int CTRL_RST   = 0;
  localparam int CTRL_SLEEP = 1;
  localparam int CTRL_AUE   = 15;
  localparam int CTRL_VAUE  = 16;
  localparam int CTRL_LOCK  = 31;
  localparam int REQ_BIT    = 15;
  localparam int BUSY_BIT   = 16;

  typedef struct packed {
    logic [REF_W-1:0]  ref_div;
    logic [FB_W-1:0]   fb_div;
    logic [POST_W-1:0] post_div;
  } div_set_t;

  typedef struct packed {
    logic vaue;
    logic aue;
    logic sleep;
    logic rst;
  } ctrl_t;
endpackage

// File: rtl/pll_idx_regs.sv
`timescale 1ns/1ps
module pll_idx_regs
  import pll_idx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [31:0]       host_wdata_i,
  input  logic              busy_i,
  input  logic              locked_i,
  output logic [31:0]       host_rdata_o,
  output logic              idx_we_o,
  output logic [ADDR_W-1:0] idx_addr_o,
  output div_set_t          staged_o,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  clksel_o,
  output logic              commit_req_o
);
  logic data_wr;
  logic unused_wdata;

  assign unused_wdata = ^host_wdata_i;
  assign data_wr      = host_we_i & host_sel_i & idx_we_o;
  assign commit_req_o = data_wr && (idx_addr_o == IDX_REFDIV) && host_wdata_i[REQ_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_we_o   <= 1'b0;
      idx_addr_o <= '0;
      staged_o   <= '0;
      ctrl_o     <= '0;
      clksel_o   <= '0;
    end else if (host_we_i && !host_sel_i) begin
      idx_we_o   <= host_wdata_i[WE_BIT];
      idx_addr_o <= host_wdata_i[ADDR_W-1:0];
    end else if (data_wr) begin
      unique case (idx_addr_o)
        IDX_CTRL: begin
          ctrl_o.rst   <= host_wdata_i[CTRL_RST];
          ctrl_o.sleep <= host_wdata_i[CTRL_SLEEP];
          ctrl_o.aue   <= host_wdata_i[CTRL_AUE];
          ctrl_o.vaue  <= host_wdata_i[CTRL_VAUE];
        end
        IDX_REFDIV: staged_o.ref_div <= host_wdata_i[REF_W-1:0];
        IDX_FBPOST: begin
          staged_o.fb_div   <= host_wdata_i[FB_W-1:0];
          staged_o.post_div <= host_wdata_i[POST_LSB +: POST_W];
        end
        IDX_CLKSEL: clksel_o <= host_wdata_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    host_rdata_o = '0;
    if (!host_sel_i) begin
      host_rdata_o[WE_BIT]     = idx_we_o;
      host_rdata_o[ADDR_W-1:0] = idx_addr_o;
    end else begin
      unique case (idx_addr_o)
        IDX_CTRL: begin
          host_rdata_o[CTRL_RST]   = ctrl_o.rst;
          host_rdata_o[CTRL_SLEEP] = ctrl_o.sleep;
          host_rdata_o[CTRL_AUE]   = ctrl_o.aue;
          host_rdata_o[CTRL_VAUE]  = ctrl_o.vaue;
          host_rdata_o[CTRL_LOCK]  = locked_i;
        end
        IDX_REFDIV: begin
          host_rdata_o[REF_W-1:0] = staged_o.ref_div;
          host_rdata_o[BUSY_BIT]  = busy_i;
        end
        IDX_FBPOST: begin
          host_rdata_o[FB_W-1:0]             = staged_o.fb_div;
          host_rdata_o[POST_LSB +: POST_W]   = staged_o.post_div;
        end
        IDX_CLKSEL: host_rdata_o[SEL_W-1:0] = clksel_o;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pll_idx_commit.sv
`timescale 1ns/1ps
module pll_idx_commit
  import pll_idx_pkg::*;
#(
  parameter int COMMIT_WAIT = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  div_set_t staged_i,
  output logic     busy_o,
  output logic     fire_o,
  output div_set_t active_o
);
  localparam int CNT_W = $clog2(COMMIT_WAIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      active_o <= '0;
    end else if (!busy_o) begin
      if (req_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_W'(COMMIT_WAIT - 1);
      end
    end else if (fire_o) begin
      busy_o   <= 1'b0;
      active_o <= staged_i;  // whole set in one edge
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pll_idx_lock.sv
`timescale 1ns/1ps
module pll_idx_lock #(
  parameter int LOCK_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic hold_i,
  output logic locked_o
);
  localparam int LCNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [LCNT_W-1:0] LOCK_MAX = LCNT_W'(LOCK_CYCLES);

  logic [LCNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (fire_i || hold_i)  cnt_q <= '0;
    else if (cnt_q != LOCK_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign locked_o = (cnt_q == LOCK_MAX) && !hold_i;
endmodule

// File: rtl/pll_index_port.sv
`timescale 1ns/1ps
module pll_index_port
  import pll_idx_pkg::*;
#(
  parameter int COMMIT_WAIT = 8,
  parameter int LOCK_CYCLES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic [POST_W-1:0] post_div_o,
  output logic              pll_reset_o,
  output logic              pll_sleep_o,
  output logic [SEL_W-1:0]  pix_clk_sel_o,
  output logic              pll_locked_o
);
  logic              idx_we;
  logic [ADDR_W-1:0] idx_addr;
  div_set_t          staged;
  div_set_t          active;
  ctrl_t             ctrl;
  logic [SEL_W-1:0]  clksel;
  logic              commit_req;
  logic              busy;
  logic              fire;

  pll_idx_regs i_regs (
    .clk_i, .rst_ni, .host_we_i, .host_sel_i, .host_wdata_i,
    .busy_i(busy), .locked_i(pll_locked_o), .host_rdata_o,
    .idx_we_o(idx_we), .idx_addr_o(idx_addr), .staged_o(staged),
    .ctrl_o(ctrl), .clksel_o(clksel), .commit_req_o(commit_req)
  );

  pll_idx_commit #(.COMMIT_WAIT(COMMIT_WAIT)) i_commit (
    .clk_i, .rst_ni, .req_i(commit_req), .staged_i(staged),
    .busy_o(busy), .fire_o(fire), .active_o(active)
  );

  pll_idx_lock #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
    .clk_i, .rst_ni, .fire_i(fire), .hold_i(ctrl.rst | ctrl.sleep),
    .locked_o(pll_locked_o)
  );

  assign ref_div_o     = active.ref_div;
  assign fb_div_o      = active.fb_div;
  assign post_div_o    = active.post_div;
  assign pll_reset_o   = ctrl.rst;
  assign pll_sleep_o   = ctrl.sleep;
  assign pix_clk_sel_o = clksel;
endmodule

// File: rtl/pll_index_port_chk.sv
`timescale 1ns/1ps
module pll_index_port_chk
  import pll_idx_pkg::*;
#(
  parameter int COMMIT_WAIT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic              host_sel_i,
  input logic [31:0]       host_rdata_o,
  input logic              idx_we,
  input logic [ADDR_W-1:0] idx_addr,
  input logic              busy,
  input div_set_t          staged,
  input div_set_t          active,
  input ctrl_t             ctrl,
  input logic [SEL_W-1:0]  clksel,
  input logic              pll_locked_o
);
  logic [15:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R5
  busy_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= 16'(COMMIT_WAIT));

  // R6
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(active));

  // R6
  commit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> active == $past(staged));

  // R8
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !pll_locked_o);

  // R2
  write_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_sel_i && !idx_we) |=>
      ($stable(staged) && $stable(ctrl) && $stable(clksel)));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_i && idx_addr != IDX_CTRL && idx_addr != IDX_REFDIV &&
     idx_addr != IDX_FBPOST && idx_addr != IDX_CLKSEL) |-> host_rdata_o == '0);
endmodule

bind pll_index_port pll_index_port_chk #(.COMMIT_WAIT(COMMIT_WAIT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_we_i(host_we_i), .host_sel_i(host_sel_i),
  .host_rdata_o(host_rdata_o), .idx_we(idx_we), .idx_addr(idx_addr),
  .busy(busy), .staged(staged), .active(active), .ctrl(ctrl),
  .clksel(clksel), .pll_locked_o(pll_locked_o)
);

// File: tb/test_pll_index_port.sv
`timescale 1ns/1ps
module test_pll_index_port;
  import pll_idx_pkg::*;

  localparam int W = 8;
  localparam int L = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0, host_sel = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [REF_W-1:0] ref_div;
  logic [FB_W-1:0] fb_div;
  logic [POST_W-1:0] post_div;
  logic pll_reset, pll_sleep, pll_locked;
  logic [SEL_W-1:0] pix_sel;

  int n_chk = 0, n_bad = 0;

  logic [31:0] m_ctrl, m_ref, m_fb, m_post, m_sel;
  logic [31:0] a_ref, a_fb, a_post;

  always #2.5 clk = ~clk;

  pll_index_port #(.COMMIT_WAIT(W), .LOCK_CYCLES(L)) i_pll_index_port (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .ref_div_o(ref_div),
    .fb_div_o(fb_div), .post_div_o(post_div), .pll_reset_o(pll_reset),
    .pll_sleep_o(pll_sleep), .pix_clk_sel_o(pix_sel), .pll_locked_o(pll_locked)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic sel, logic [31:0] d);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic host_rd(logic sel, output logic [31:0] d);
    host_we = 1'b0; host_sel = sel;
    #0.5;
    d = host_rdata;
  endtask

  task automatic set_idx(logic [ADDR_W-1:0] a, logic we);
    host_wr(1'b0, (32'(we) << WE_BIT) | 32'(a));
  endtask

  function automatic logic [31:0] exp_data(logic [ADDR_W-1:0] a);
    case (a)
      IDX_CTRL:   return m_ctrl;
      IDX_REFDIV: return m_ref;
      IDX_FBPOST: return m_fb | (m_post << POST_LSB);
      IDX_CLKSEL: return m_sel;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    case (a)
      IDX_CTRL:   m_ctrl = d & ((32'h1 << CTRL_RST) | (32'h1 << CTRL_SLEEP) |
                                (32'h1 << CTRL_AUE) | (32'h1 << CTRL_VAUE));
      IDX_REFDIV: m_ref  = d & 32'h3FF;
      IDX_FBPOST: begin m_fb = d & 32'h7FF; m_post = (d >> POST_LSB) & 32'h7; end
      IDX_CLKSEL: m_sel  = d & 32'h3;
      default: ;
    endcase
  endtask

  task automatic write_reg(logic [ADDR_W-1:0] a, logic [31:0] d);
    set_idx(a, 1'b1);
    host_wr(1'b1, d);
    model_wr(a, d);
  endtask

  task automatic read_reg(logic [ADDR_W-1:0] a, output logic [31:0] d);
    set_idx(a, 1'b0);
    host_rd(1'b1, d);
  endtask

  task automatic chk_active(string req);
    chk({req, " ref"},  32'(ref_div),  a_ref);
    chk({req, " fb"},   32'(fb_div),   a_fb);
    chk({req, " post"}, 32'(post_div), a_post);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, saved;
    int n;
    void'($urandom(32'd20240611));
    m_ctrl = 0; m_ref = 0; m_fb = 0; m_post = 0; m_sel = 0;
    a_ref = 0; a_fb = 0; a_post = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R10 / R1 reset state
    host_rd(1'b0, rd);  chk("R1 index reset", rd, 32'h0);
    chk("R10 clk sel", 32'(pix_sel), 32'h0);
    chk("R10 reset/sleep", {30'h0, pll_reset, pll_sleep}, 32'h0);
    chk("R10 locked", 32'(pll_locked), 32'h0);
    chk_active("R10");
    read_reg(IDX_REFDIV, rd); chk("R10 refdiv/busy", rd, 32'h0);

    // R1 index field layout, bit 6 dropped
    host_wr(1'b0, 32'hFFFF_FFFF);
    host_rd(1'b0, rd);  chk("R1 index fields", rd, 32'h0000_00BF);

    // R2 R3 R4 random window traffic
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      logic we;
      logic [31:0] d;
      case ($urandom % 5)
        0: a = IDX_CTRL;
        1: a = IDX_REFDIV;
        2: a = IDX_FBPOST;
        3: a = IDX_CLKSEL;
        default: a = ADDR_W'($urandom);
      endcase
      we = 1'($urandom);
      d = $urandom;
      if (a == IDX_REFDIV) d[REQ_BIT] = 1'b0;
      set_idx(a, we);
      host_wr(1'b1, d);
      if (we) model_wr(a, d);
      set_idx(a, 1'b0);
      host_rd(1'b0, rd); chk("R1 index readback", rd, 32'(a));
      host_rd(1'b1, rd);
      if (a == IDX_CTRL) rd[CTRL_LOCK] = 1'b0;
      chk("R2 R3 R4 readback", rd, exp_data(a));
      chk("R7 reset pin", 32'(pll_reset), m_ctrl & 32'h1);
      chk("R7 clk sel pin", 32'(pix_sel), m_sel);
      chk("R6 no commit", 32'(fb_div), a_fb);
    end

    // R7 R8 hold bits
    write_reg(IDX_CTRL, 32'h1);
    chk("R7 reset high", 32'(pll_reset), 32'h1);
    chk("R8 locked under reset", 32'(pll_locked), 32'h0);
    write_reg(IDX_CTRL, 32'h2);
    chk("R7 sleep high", 32'(pll_sleep), 32'h1);
    chk("R8 locked under sleep", 32'(pll_locked), 32'h0);
    write_reg(IDX_CTRL, 32'h0);
    write_reg(IDX_CLKSEL, 32'h0);
    chk("R7 cpu clock", 32'(pix_sel), 32'h0);

    // R5 R6 R8 commit
    write_reg(IDX_FBPOST, 32'h0005_02AB);
    write_reg(IDX_REFDIV, 32'h155);
    host_wr(1'b1, 32'h0000_8155);
    n = 0;
    host_rd(1'b1, rd);
    chk("R3 req bit reads 0", rd & 32'h8000, 32'h0);
    chk_active("R6 before commit");
    while (rd[BUSY_BIT] && n < 10000) begin
      n++;
      @(posedge clk); #1;
      host_rd(1'b1, rd);
    end
    chk("R5 busy cycles", n, W);
    a_ref = m_ref; a_fb = m_fb; a_post = m_post;
    chk_active("R6 after commit");
    chk("R8 lock drop", 32'(pll_locked), 32'h0);
    repeat (L - 1) @(posedge clk);
    #1 chk("R8 lock not yet", 32'(pll_locked), 32'h0);
    @(posedge clk);
    #1 chk("R8 lock rises", 32'(pll_locked), 32'h1);
    read_reg(IDX_CTRL, rd); chk("R8 lock readback", rd, 32'h8000_0000);
    write_reg(IDX_CLKSEL, 32'h3);
    chk("R7 pll clock", 32'(pix_sel), 32'h3);

    // R5 second request while busy is ignored
    write_reg(IDX_REFDIV, 32'h0AA);
    host_wr(1'b1, 32'h0000_80AA);
    repeat (2) @(posedge clk);
    #1 host_wr(1'b1, 32'h0000_80AA);
    n = 0;
    host_rd(1'b1, rd);
    while (rd[BUSY_BIT] && n < 10000) begin
      n++;
      @(posedge clk); #1;
      host_rd(1'b1, rd);
    end
    chk("R5 re-request ignored", n, W - 3);
    a_ref = m_ref;
    chk_active("R5 commit");

    // R6 staging write on the commit edge
    set_idx(IDX_REFDIV, 1'b1);
    host_wr(1'b1, 32'h0000_80AA);
    set_idx(IDX_FBPOST, 1'b1);
    repeat (W - 2) @(posedge clk);
    #1 host_wr(1'b1, 32'h0003_0123);
    chk_active("R6 collision old value");
    model_wr(IDX_FBPOST, 32'h0003_0123);
    host_rd(1'b1, rd); chk("R6 collision staged", rd, 32'h0003_0123);
    set_idx(IDX_REFDIV, 1'b1);
    host_wr(1'b1, 32'h0000_80AA);
    repeat (W + 1) @(posedge clk);
    #1 a_fb = m_fb; a_post = m_post;
    chk_active("R6 second commit");

    // R9 dummy access
    set_idx(IDX_FBPOST, 1'b1);
    host_rd(1'b0, saved);
    set_idx(6'h00, 1'b0);
    host_rd(1'b1, rd); chk("R9 R4 index 0 reads 0", rd, 32'h0);
    host_wr(1'b0, saved);
    host_rd(1'b0, rd); chk("R9 index restored", rd, saved);
    host_rd(1'b1, rd); chk("R9 staged unchanged", rd, exp_data(IDX_FBPOST));
    chk_active("R9");
    chk("R9 clk sel", 32'(pix_sel), m_sel);

    // R4 unmapped write has no effect
    write_reg(6'h3F, 32'hFFFF_FFFF);
    host_rd(1'b1, rd); chk("R4 unmapped read", rd, 32'h0);
    read_reg(IDX_FBPOST, rd); chk("R4 others intact", rd, exp_data(IDX_FBPOST));

    // R2 disabled write
    set_idx(IDX_CLKSEL, 1'b0);
    host_wr(1'b1, 32'h0);
    chk("R2 gated write", 32'(pix_sel), m_sel);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule